// File: doc/BRIEF.md
# Multi-Domain Dynamic Clock Gate Controller

This block decides, on every edge of the free-running clock, whether each of three processor sub-domains receives a clock: the integer execution core, the system-control coprocessor block and, when the build includes it, the data engine. Each domain has its own idle test, built from status lines that the pipeline, caches, translation unit, linefill buffers, debug logic and performance monitor drive. A domain's clock is cut only while its idle test holds and gating is switched on.

Software controls the block through one small register on a plain write/read port. The register holds a global gating switch and a 3-bit wake-up lead field. The memory system and the dispatch logic can send a "wake in N cycles" hint for each domain. When N is at or below the lead field, the domain is woken, or kept awake, ahead of the event. Each clock enable comes from a flop, and a behavioural latch-based cell turns it into a glitch-free gated clock. After every wake-up the domain runs for at least one full cycle before it can be cut again.

Top module: `dyn_clk_gate_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every clock enable is 1 and the register reads back 0.
- R2: Register bit 0 is the gating switch and bits 10:8 are the wake lead. Every other bit reads 0, so writing all ones reads back 32'h0000_0701.
- R3: A write that clears bit 0 makes all clock enables 1 after the edge that takes the write, even for domains that were cut. They stay 1 while the switch is clear.
- R4: With gating on, the core clock is cut when the core is empty and either an instruction fetch waits on a linefill or an instruction translation miss is outstanding.
- R5: With gating on, the core clock is cut when the core is full and either a data access waits on a linefill or stores stall on busy linefill buffers. An empty core with only a data miss is not cut.
- R6: With gating on, the system-control clock is cut only when no coprocessor instruction is executing, none is in the pipeline, event counting is off and debug is off. Any one of these becoming active restores the clock.
- R7: With gating on and the data engine built (HAS_DE=1), its clock is cut when it holds no instruction and none is in the pipeline. With HAS_DE=0 its enable is always 1.
- R8: When a cut domain's idle test stops holding, its enable is 1 after the next edge.
- R9: A valid wake hint whose cycle count is at or below the lead field wakes a cut domain after the next edge and prevents a cut on that edge. A count above the field has no effect.
- R10: After an enable rises, it stays 1 for at least the following cycle, whatever the idle test says.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| core_empty | input | 1 | Integer core holds no instruction |
| core_full | input | 1 | Integer core pipeline is full |
| ic_fill_wait | input | 1 | Instruction miss waiting on a linefill |
| itlb_miss | input | 1 | Instruction translation miss outstanding |
| dc_fill_wait | input | 1 | Data miss waiting on a linefill |
| st_lfb_stall | input | 1 | Stores stalled, all linefill buffers busy |
| cp_exec | input | 1 | Coprocessor instruction executing |
| cp_in_pipe | input | 1 | Coprocessor instruction in the pipeline |
| pmu_evt_en | input | 1 | Performance event counting enabled |
| dbg_en | input | 1 | Debug enabled |
| de_busy | input | 1 | Data engine holds an instruction |
| de_in_pipe | input | 1 | Data engine instruction in the pipeline |
| wake_vld | input | 3 | Wake hint valid per domain (2 core, 1 system, 0 engine) |
| wake_cyc | input | 9 | Wake hint cycle count, 3 bits per domain, same order |
| clk_en | output | 3 | Registered clock enable per domain |
| gclk | output | 3 | Gated clock per domain |

## Verification
The hardest case to reach is the interaction of the one-cycle hold after wake-up with a wake hint that keeps arriving. A cut domain must wake, sit through its hold cycle, and then stay up only because the hint still qualifies, even though its idle test holds the whole time. The stimulus table reaches this with consecutive vectors that keep the data engine idle and repeat the same qualifying hint over three edges, then drop the hint and expect the cut. In a similar way, the boundary of the lead field is reached by rewriting it to zero while all domains are cut and offering counts of one and then zero.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  localparam int NUM_DOM  = 3;
  localparam int DOM_DE   = 0;
  localparam int DOM_SYS  = 1;
  localparam int DOM_CORE = 2;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LAT_LSB = 8;

  typedef enum logic [1:0] {
    DOM_RUN  = 2'd0,
    DOM_HOLD = 2'd1,
    DOM_CUT  = 2'd2
  } dom_state_e;
endpackage

// File: rtl/dcg_cfg_reg.sv
module dcg_cfg_reg #(
  parameter int DATA_W  = 32,
  parameter int LAT_W   = 3,
  parameter int EN_BIT  = 0,
  parameter int LAT_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_q_o,
  output logic [LAT_W-1:0]  lat_q_o,
  output logic              en_eff_o,
  output logic [LAT_W-1:0]  lat_eff_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic             en_q, en_d;
  logic [LAT_W-1:0] lat_q, lat_d;

  // next-state: a write is forwarded so the domains see it on the same edge
  always_comb begin
    en_d  = en_q;
    lat_d = lat_q;
    if (wr_i) begin
      en_d  = wdata_i[EN_BIT];
      lat_d = wdata_i[LAT_LSB +: LAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lat_q <= '0;
    end else if (wr_i) begin
      en_q  <= en_d;
      lat_q <= lat_d;
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[EN_BIT]             = en_q;
    rdata_o[LAT_LSB +: LAT_W]   = lat_q;
  end

  assign en_q_o    = en_q;
  assign lat_q_o   = lat_q;
  assign en_eff_o  = en_d;
  assign lat_eff_o = lat_d;
endmodule

// File: rtl/dcg_idle_cond.sv
module dcg_idle_cond
  import dcg_pkg::*;
#(
  parameter bit HAS_DE = 1'b1
) (
  input  logic               core_empty_i,
  input  logic               core_full_i,
  input  logic               ic_fill_wait_i,
  input  logic               itlb_miss_i,
  input  logic               dc_fill_wait_i,
  input  logic               st_lfb_stall_i,
  input  logic               cp_exec_i,
  input  logic               cp_in_pipe_i,
  input  logic               pmu_evt_en_i,
  input  logic               dbg_en_i,
  input  logic               de_busy_i,
  input  logic               de_in_pipe_i,
  output logic [NUM_DOM-1:0] idle_o
);
  logic core_starved;
  logic core_blocked;
  logic sys_quiet;

  // front end empty and waiting on fetch or translation
  assign core_starved = core_empty_i & (ic_fill_wait_i | itlb_miss_i);
  // back end full and waiting on data side
  assign core_blocked = core_full_i & (dc_fill_wait_i | st_lfb_stall_i);
  assign sys_quiet    = ~(cp_exec_i | cp_in_pipe_i | pmu_evt_en_i | dbg_en_i);

  assign idle_o[DOM_CORE] = core_starved | core_blocked;
  assign idle_o[DOM_SYS]  = sys_quiet;

  generate
    if (HAS_DE) begin : g_de
      assign idle_o[DOM_DE] = ~(de_busy_i | de_in_pipe_i);
    end else begin : g_no_de
      assign idle_o[DOM_DE] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dcg_dom_ctrl.sv
module dcg_dom_ctrl
  import dcg_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             idle_i,
  input  logic             wake_vld_i,
  input  logic [LAT_W-1:0] wake_cyc_i,
  output logic             clk_en_o
);
  dom_state_e st_q, st_d;
  logic       en_q, en_d;
  logic       hint_ok;
  logic       may_cut;

  assign hint_ok = wake_vld_i && (wake_cyc_i <= lat_i);
  assign may_cut = gate_en_i && idle_i && !hint_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DOM_RUN:  if (may_cut) st_d = DOM_CUT;
      DOM_HOLD: st_d = DOM_RUN;
      DOM_CUT:  if (!may_cut) st_d = DOM_HOLD;
      default:  st_d = DOM_RUN;
    endcase
  end

  assign en_d = (st_d != DOM_CUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DOM_RUN;
      en_q <= 1'b1;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign clk_en_o = en_q;
endmodule

// File: rtl/dcg_cg_cell.sv
module dcg_cg_cell (
  input  logic clk,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // behavioural model: enable captured while clock is low
  always_latch begin
    if (!clk) en_lat = en_i;
  end

  assign gclk_o = clk & en_lat;
endmodule

// File: rtl/dyn_clk_gate_ctrl.sv
module dyn_clk_gate_ctrl
  import dcg_pkg::*;
#(
  parameter bit HAS_DE = 1'b1,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  input  logic                     core_empty,
  input  logic                     core_full,
  input  logic                     ic_fill_wait,
  input  logic                     itlb_miss,
  input  logic                     dc_fill_wait,
  input  logic                     st_lfb_stall,
  input  logic                     cp_exec,
  input  logic                     cp_in_pipe,
  input  logic                     pmu_evt_en,
  input  logic                     dbg_en,
  input  logic                     de_busy,
  input  logic                     de_in_pipe,
  input  logic [NUM_DOM-1:0]       wake_vld,
  input  logic [NUM_DOM*LAT_W-1:0] wake_cyc,
  output logic [NUM_DOM-1:0]       clk_en,
  output logic [NUM_DOM-1:0]       gclk
);
  logic               cfg_en_q;
  logic [LAT_W-1:0]   cfg_lat_q;
  logic               cfg_en_eff;
  logic [LAT_W-1:0]   cfg_lat_eff;
  logic [NUM_DOM-1:0] dom_idle;

  dcg_cfg_reg #(
    .DATA_W (DATA_W),
    .LAT_W  (LAT_W),
    .EN_BIT (CFG_EN_BIT),
    .LAT_LSB(CFG_LAT_LSB)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .en_q_o   (cfg_en_q),
    .lat_q_o  (cfg_lat_q),
    .en_eff_o (cfg_en_eff),
    .lat_eff_o(cfg_lat_eff),
    .rdata_o  (cfg_rdata)
  );

  dcg_idle_cond #(.HAS_DE(HAS_DE)) u_cond (
    .core_empty_i  (core_empty),
    .core_full_i   (core_full),
    .ic_fill_wait_i(ic_fill_wait),
    .itlb_miss_i   (itlb_miss),
    .dc_fill_wait_i(dc_fill_wait),
    .st_lfb_stall_i(st_lfb_stall),
    .cp_exec_i     (cp_exec),
    .cp_in_pipe_i  (cp_in_pipe),
    .pmu_evt_en_i  (pmu_evt_en),
    .dbg_en_i      (dbg_en),
    .de_busy_i     (de_busy),
    .de_in_pipe_i  (de_in_pipe),
    .idle_o        (dom_idle)
  );

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      dcg_dom_ctrl #(.LAT_W(LAT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en_i (cfg_en_eff),
        .lat_i     (cfg_lat_eff),
        .idle_i    (dom_idle[d]),
        .wake_vld_i(wake_vld[d]),
        .wake_cyc_i(wake_cyc[d*LAT_W +: LAT_W]),
        .clk_en_o  (clk_en[d])
      );

      dcg_cg_cell u_cg (
        .clk   (clk),
        .en_i  (clk_en[d]),
        .gclk_o(gclk[d])
      );
    end
  endgenerate
endmodule

// File: rtl/dcg_chk.sv
module dcg_chk
  import dcg_pkg::*;
#(
  parameter bit HAS_DE = 1'b1,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_wr,
  input logic [DATA_W-1:0]        cfg_wdata,
  input logic                     cfg_en_q,
  input logic [LAT_W-1:0]         cfg_lat_q,
  input logic [NUM_DOM-1:0]       dom_idle,
  input logic [NUM_DOM-1:0]       wake_vld,
  input logic [NUM_DOM*LAT_W-1:0] wake_cyc,
  input logic [NUM_DOM-1:0]       clk_en
);
  AST_OFF_WRITE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_wdata[CFG_EN_BIT]) |=> (&clk_en)); // R3
  AST_OFF_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_q && !$past(cfg_en_q)) |-> (&clk_en)); // R3

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en[d] && !dom_idle[d]) |=> clk_en[d]); // R8
      AST_HOLD_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en[d]) |=> clk_en[d]); // R10
      AST_HINT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en[d] && !cfg_wr && wake_vld[d] &&
         (wake_cyc[d*LAT_W +: LAT_W] <= cfg_lat_q)) |=> clk_en[d]); // R9
      AST_CUT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en[d]) |-> $past(dom_idle[d])); // R6
    end
    if (!HAS_DE) begin : g_no_de
      AST_NO_DE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en[DOM_DE]); // R7
    end
  endgenerate
endmodule

bind dyn_clk_gate_ctrl dcg_chk #(
  .HAS_DE(HAS_DE),
  .DATA_W(DATA_W),
  .LAT_W (LAT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_wdata(cfg_wdata),
  .cfg_en_q (cfg_en_q),
  .cfg_lat_q(cfg_lat_q),
  .dom_idle (dom_idle),
  .wake_vld (wake_vld),
  .wake_cyc (wake_cyc),
  .clk_en   (clk_en)
);

// File: tb/test_dyn_clk_gate_ctrl.sv
`timescale 1ns/1ps
module test_dyn_clk_gate_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata, nde_rdata;
  logic core_empty, core_full, ic_fill_wait, itlb_miss, dc_fill_wait, st_lfb_stall;
  logic cp_exec, cp_in_pipe, pmu_evt_en, dbg_en, de_busy, de_in_pipe;
  logic [2:0] wake_vld;
  logic [8:0] wake_cyc;
  logic [2:0] clk_en, gclk, nde_en, nde_gclk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  dyn_clk_gate_ctrl i_dyn_clk_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .core_empty(core_empty), .core_full(core_full), .ic_fill_wait(ic_fill_wait),
    .itlb_miss(itlb_miss), .dc_fill_wait(dc_fill_wait), .st_lfb_stall(st_lfb_stall),
    .cp_exec(cp_exec), .cp_in_pipe(cp_in_pipe), .pmu_evt_en(pmu_evt_en), .dbg_en(dbg_en),
    .de_busy(de_busy), .de_in_pipe(de_in_pipe), .wake_vld(wake_vld), .wake_cyc(wake_cyc),
    .clk_en(clk_en), .gclk(gclk)
  );

  dyn_clk_gate_ctrl #(.HAS_DE(1'b0)) i_dyn_clk_gate_ctrl_nde (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(nde_rdata),
    .core_empty(core_empty), .core_full(core_full), .ic_fill_wait(ic_fill_wait),
    .itlb_miss(itlb_miss), .dc_fill_wait(dc_fill_wait), .st_lfb_stall(st_lfb_stall),
    .cp_exec(cp_exec), .cp_in_pipe(cp_in_pipe), .pmu_evt_en(pmu_evt_en), .dbg_en(dbg_en),
    .de_busy(de_busy), .de_in_pipe(de_in_pipe), .wake_vld(wake_vld), .wake_cyc(wake_cyc),
    .clk_en(nde_en), .gclk(nde_gclk)
  );

  // {core[6] empty,full,ic,itlb,dc,st | sys[4] cpx,cpp,pmu,dbg | de[2] busy,pipe |
  //  wake_vld[3] | cyc[3] | exp clk_en{core,sys,de}[3] | req[4]}; lead field = 2
  localparam int NV = 31;
  localparam logic [24:0] VEC [NV] = '{
    {6'b101000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b011, 4'd4},  // R4 empty + fetch fill
    {6'b101000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b011, 4'd4},  // R4 stays cut
    {6'b100100, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b011, 4'd4},  // R4 empty + itlb miss
    {6'b000000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd8},  // R8 wake next edge
    {6'b101000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd10}, // R10 hold cycle
    {6'b101000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b011, 4'd4},  // R4 cut after hold
    {6'b010010, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b011, 4'd5},  // R5 full + data fill
    {6'b010001, 4'b0001, 2'b10, 3'b100, 3'd2, 3'b111, 4'd9},  // R9 hint at lead wakes
    {6'b010001, 4'b0001, 2'b10, 3'b100, 3'd3, 3'b111, 4'd10}, // R10 hold
    {6'b010001, 4'b0001, 2'b10, 3'b100, 3'd3, 3'b011, 4'd9},  // R9 hint above lead: cut
    {6'b010001, 4'b0001, 2'b10, 3'b100, 3'd3, 3'b011, 4'd9},  // R9 no wake
    {6'b010001, 4'b0001, 2'b10, 3'b100, 3'd2, 3'b111, 4'd9},  // R9 wake
    {6'b100010, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd5},  // R5 empty + data miss
    {6'b100010, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd5},  // R5 not cut
    {6'b000000, 4'b0000, 2'b10, 3'b000, 3'd0, 3'b101, 4'd6},  // R6 all quiet
    {6'b000000, 4'b0010, 2'b10, 3'b000, 3'd0, 3'b111, 4'd6},  // R6 events on
    {6'b000000, 4'b0000, 2'b10, 3'b000, 3'd0, 3'b111, 4'd10}, // R10 hold
    {6'b000000, 4'b0000, 2'b10, 3'b000, 3'd0, 3'b101, 4'd6},  // R6 cut again
    {6'b000000, 4'b0100, 2'b10, 3'b000, 3'd0, 3'b111, 4'd6},  // R6 cp in pipe
    {6'b000000, 4'b1000, 2'b10, 3'b000, 3'd0, 3'b111, 4'd6},  // R6 cp executing
    {6'b000000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd6},  // R6 debug on
    {6'b000000, 4'b0001, 2'b00, 3'b000, 3'd0, 3'b110, 4'd7},  // R7 engine idle
    {6'b000000, 4'b0001, 2'b01, 3'b000, 3'd0, 3'b111, 4'd7},  // R7 dispatch pending
    {6'b000000, 4'b0001, 2'b00, 3'b000, 3'd0, 3'b111, 4'd10}, // R10 hold
    {6'b000000, 4'b0001, 2'b00, 3'b000, 3'd0, 3'b110, 4'd7},  // R7 cut
    {6'b000000, 4'b0001, 2'b00, 3'b001, 3'd1, 3'b111, 4'd9},  // R9 hint wakes engine
    {6'b000000, 4'b0001, 2'b00, 3'b001, 3'd1, 3'b111, 4'd9},  // R9 hold
    {6'b000000, 4'b0001, 2'b00, 3'b001, 3'd1, 3'b111, 4'd9},  // R9 hint blocks cut
    {6'b000000, 4'b0001, 2'b00, 3'b000, 3'd0, 3'b110, 4'd7},  // R7 cut once hint gone
    {6'b101000, 4'b0000, 2'b00, 3'b000, 3'd0, 3'b000, 4'd6},  // R6 all domains cut
    {6'b101000, 4'b0000, 2'b00, 3'b000, 3'd0, 3'b000, 4'd6}   // R6 remain cut
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] d);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    cycle();
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic apply(input logic [24:0] v);
    {core_empty, core_full, ic_fill_wait, itlb_miss, dc_fill_wait, st_lfb_stall} = v[24:19];
    {cp_exec, cp_in_pipe, pmu_evt_en, dbg_en} = v[18:15];
    {de_busy, de_in_pipe} = v[14:13];
    wake_vld = v[12:10];
    wake_cyc = {3{v[9:7]}};
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    apply({6'b000000, 4'b0001, 2'b10, 3'b000, 3'd0, 3'b111, 4'd0});
    repeat (3) @(negedge clk);
    check("R1 reset enables", {29'd0, clk_en}, 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 enables after release", {29'd0, clk_en}, 32'h7);
    check("R1 register reset", cfg_rdata, 32'h0);

    reg_write(32'hFFFF_FFFF);
    check("R2 reserved bits read zero", cfg_rdata, 32'h0000_0701);
    reg_write(32'h0000_0201);
    check("R2 lead field readback", cfg_rdata, 32'h0000_0201);
    check("R2 busy domains stay on", {29'd0, clk_en}, 32'h7);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      cycle();
      checks++;
      if (clk_en !== VEC[i][6:4]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b", VEC[i][3:0], i, clk_en, VEC[i][6:4]);
      end
      check("R7 no engine variant", {29'd0, nde_en}, {29'd0, VEC[i][6:5], 1'b1});
    end

    // R3: clearing the switch while every domain is cut
    reg_write(32'h0000_0000);
    check("R3 forced on after write", {29'd0, clk_en}, 32'h7);
    cycle();
    check("R3 stays on", {29'd0, clk_en}, 32'h7);
    cycle();
    check("R3 stays on later", {29'd0, clk_en}, 32'h7);

    // R9 boundary with lead 0
    reg_write(32'h0000_0001);
    check("R9 lead0 all cut", {29'd0, clk_en}, 32'h0);
    wake_vld = 3'b100;
    wake_cyc = {3'd1, 3'd0, 3'd0};
    cycle();
    check("R9 count above lead ignored", {29'd0, clk_en}, 32'h0);
    wake_cyc = {3'd0, 3'd0, 3'd0};
    cycle();
    check("R9 count equal lead wakes", {29'd0, clk_en}, 32'h4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule